// File: doc/BRIEF.md
# DTMF Tone-Pair Frequency Decoder

This block recognises a dual-tone keypad digit from two square-wave inputs. One input carries the low-band (row) tone and the other carries the high-band (column) tone. Each input has already been filtered and squared up outside the block. Each band has its own lane. A lane synchronises its input and counts reference-clock cycles between successive rising edges. It then sorts the measured period into one of four frequency bins, each bin a window of counts around a nominal tone. A small state machine per lane declares the band valid only when two back-to-back periods land in the same bin.

When both lanes are valid, the block raises `early_steer` and presents the 4-bit key code for the row/column pair. Steering drops as soon as either lane loses its tone. A lane loses its tone through a mismatching period, through a change of bin, or through a counter that runs to its limit with no edge. The reference frequency (`CLK_HZ`) and the tolerance in parts per thousand (`TOL_PERMIL`) are parameters.

Each lane's state machine has four states:
- `BAND_IDLE`: no timing reference.
- `BAND_ARMED`: one edge seen, no matching period yet.
- `BAND_CAND`: one matching period, held as the candidate bin.
- `BAND_LOCK`: valid.

Its transitions are:
- IDLE to ARMED on any edge.
- Any non-idle state to ARMED on an edge whose period matches no bin.
- ARMED to CAND on a matching edge.
- CAND or LOCK to CAND on a matching edge whose bin differs from the held one.
- CAND or LOCK to LOCK on a matching edge whose bin equals the held one.
- Any non-idle state to IDLE when the counter overflows with no edge.

Top module: `dtmf_pair_decoder`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `early_steer` is 0.
- R2: A period is the number of reference cycles between two consecutive rising edges of a band input. It matches tone f when `floor(CLK_HZ*(1000-TOL)/(1000*f)) <= period <= floor(CLK_HZ*(1000+TOL)/(1000*f))`, and both bounds are inclusive.
- R3: The row bins are 697, 770, 852 and 941 Hz, with row indices 0 to 3. The column bins are 1209, 1336, 1477 and 1633 Hz, with column indices 0 to 3.
- R4: `digit_code` for rows 0-2 and columns 0-2 is row*3+col+1 (keys 1 to 9). Row 3 gives 1011 (*) with column 0, 1010 (0) with column 1, and 1100 (#) with column 2.
- R5: Column 3 gives 1101, 1110, 1111 and 0000 for rows 0, 1, 2 and 3 (keys A, B, C, D).
- R6: A lane is valid only after two consecutive periods fall in the same bin. A tone whose periods alternate between two bins never raises `early_steer`.
- R7: A period outside every bin makes the lane invalid. This covers a period one count outside a bin bound and a period in the gap between bins.
- R8: A lane overflows when its count reaches LIMIT with no edge. LIMIT is the upper bound of the band's lowest tone plus one. When a band input stops, `early_steer` falls on the (LIMIT+4)th clock edge after that input's last rising edge.
- R9: When the other band is already valid, `early_steer` rises on the 4th clock edge after the rising edge that completes the second matching period.
- R10: While `early_steer` stays 1, `digit_code` does not change.
- R11: `early_steer` is 1 exactly when both lanes hold valid bins, on the cycle after they do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock of CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| tone_low | input | 1 | Squared row-band tone |
| tone_high | input | 1 | Squared column-band tone |
| early_steer | output | 1 | Both bands hold a valid tone |
| digit_code | output | 4 | Key code of the row/column pair; meaningful while early_steer is 1 |

## Verification
Each input passes through a two-flop synchroniser and an edge flop. The lane state and the output register each add one more edge. So a lock is seen 4 edges after the input rise that completes it, and an overflow is seen LIMIT+4 edges after the last rise. The timing tests record the cycle of that rise and sample `early_steer` on both sides of the due edge. Steady-state checks first let the tones settle for more than three of the slowest periods, so the result no longer depends on phase. They then watch the outputs for several hundred more cycles to confirm they hold.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int TONES = 4;
    localparam int IDX_W = 2;

    typedef enum logic [1:0] {
        BAND_IDLE,
        BAND_ARMED,
        BAND_CAND,
        BAND_LOCK
    } band_state_e;

    // band 0 = row group, band 1 = column group
    function automatic int tone_hz(input int band, input int idx);
        int f;
        if (band == 0) begin
            case (idx)
                0:       f = 697;
                1:       f = 770;
                2:       f = 852;
                default: f = 941;
            endcase
        end else begin
            case (idx)
                0:       f = 1209;
                1:       f = 1336;
                2:       f = 1477;
                default: f = 1633;
            endcase
        end
        return f;
    endfunction

    function automatic longint bin_min(input longint clk_hz, input int tol, input int hz);
        return (clk_hz * longint'(1000 - tol)) / longint'(1000 * hz);
    endfunction

    function automatic longint bin_max(input longint clk_hz, input int tol, input int hz);
        return (clk_hz * longint'(1000 + tol)) / longint'(1000 * hz);
    endfunction

endpackage

// File: rtl/dtmf_edge_timer.sv
module dtmf_edge_timer #(
    parameter int     CNT_W = 12,
    parameter longint LIMIT = 1500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tone_in,
    output logic             edge_o,
    output logic [CNT_W-1:0] period_o,
    output logic             ovf_o
);
    localparam logic [CNT_W-1:0] LIM = CNT_W'(LIMIT);

    logic             s1, s2, s3;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1  <= 1'b0;
            s2  <= 1'b0;
            s3  <= 1'b0;
            cnt <= LIM;
        end else begin
            s1 <= tone_in;
            s2 <= s1;
            s3 <= s2;
            if (edge_o)
                cnt <= CNT_W'(1);
            else if (cnt != LIM)
                cnt <= cnt + CNT_W'(1);
        end
    end

    assign edge_o   = s2 & ~s3;
    assign period_o = cnt;
    assign ovf_o    = (cnt == LIM) & ~edge_o;

endmodule

// File: rtl/dtmf_period_bin.sv
module dtmf_period_bin
    import dtmf_pkg::*;
#(
    parameter longint CLK_HZ     = 1_000_000,
    parameter int     TOL_PERMIL = 25,
    parameter int     BAND       = 0,
    parameter int     CNT_W      = 12
) (
    input  logic [CNT_W-1:0] period,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    logic [TONES-1:0] match;

    for (genvar k = 0; k < TONES; k++) begin : g_bin
        localparam longint LO = bin_min(CLK_HZ, TOL_PERMIL, tone_hz(BAND, k));
        localparam longint HI = bin_max(CLK_HZ, TOL_PERMIL, tone_hz(BAND, k));
        assign match[k] = (longint'(period) >= LO) && (longint'(period) <= HI);
    end

    always_comb begin
        idx = '0;
        for (int k = 0; k < TONES; k++)
            if (match[k]) idx = IDX_W'(k);
    end

    assign hit = |match;

endmodule

// File: rtl/dtmf_band_fsm.sv
module dtmf_band_fsm
    import dtmf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             edge_i,
    input  logic             ovf_i,
    input  logic             hit_i,
    input  logic [IDX_W-1:0] idx_i,
    output logic             locked,
    output logic [IDX_W-1:0] bin_o
);
    band_state_e      state, state_d;
    logic [IDX_W-1:0] bin_q, bin_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= BAND_IDLE;
            bin_q <= '0;
        end else begin
            state <= state_d;
            bin_q <= bin_d;
        end
    end

    always_comb begin
        state_d = state;
        bin_d   = bin_q;
        unique case (state)
            BAND_IDLE: begin
                if (edge_i) state_d = BAND_ARMED;
            end
            BAND_ARMED, BAND_CAND, BAND_LOCK: begin
                if (edge_i) begin
                    if (!hit_i) begin
                        state_d = BAND_ARMED;
                    end else if (state != BAND_ARMED && idx_i == bin_q) begin
                        state_d = BAND_LOCK;
                    end else begin
                        state_d = BAND_CAND;
                        bin_d   = idx_i;
                    end
                end else if (ovf_i) begin
                    state_d = BAND_IDLE;
                end
            end
        endcase
    end

    always_comb begin
        locked = (state == BAND_LOCK);
        bin_o  = bin_q;
    end

endmodule

// File: rtl/dtmf_pair_decoder.sv
module dtmf_pair_decoder
    import dtmf_pkg::*;
#(
    parameter longint CLK_HZ     = 1_000_000,
    parameter int     TOL_PERMIL = 25
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tone_low,
    input  logic       tone_high,
    output logic       early_steer,
    output logic [3:0] digit_code
);
    localparam longint LIM_TOP = bin_max(CLK_HZ, TOL_PERMIL, tone_hz(0, 0)) + 1;
    localparam int     CNT_W   = $clog2(LIM_TOP + 1);

    logic [1:0]       band_in;
    logic [1:0]       band_lock;
    logic [1:0]       band_edge;
    logic [IDX_W-1:0] band_bin [2];
    logic [3:0]       code_d;
    logic             pair_ok;

    assign band_in = {tone_high, tone_low};

    for (genvar b = 0; b < 2; b++) begin : g_lane
        localparam longint LIMIT = bin_max(CLK_HZ, TOL_PERMIL, tone_hz(b, 0)) + 1;
        logic [CNT_W-1:0] period;
        logic             ovf, hit;
        logic [IDX_W-1:0] idx;

        dtmf_edge_timer #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_timer (
            .clk(clk), .rst_n(rst_n), .tone_in(band_in[b]),
            .edge_o(band_edge[b]), .period_o(period), .ovf_o(ovf)
        );

        dtmf_period_bin #(.CLK_HZ(CLK_HZ), .TOL_PERMIL(TOL_PERMIL), .BAND(b), .CNT_W(CNT_W)) u_bin (
            .period(period), .hit(hit), .idx(idx)
        );

        dtmf_band_fsm u_fsm (
            .clk(clk), .rst_n(rst_n), .edge_i(band_edge[b]), .ovf_i(ovf),
            .hit_i(hit), .idx_i(idx), .locked(band_lock[b]), .bin_o(band_bin[b])
        );
    end

    assign pair_ok = &band_lock;

    // row = band_bin[0], column = band_bin[1]
    always_comb begin
        if (band_bin[1] == 2'd3) begin
            unique case (band_bin[0])
                2'd0: code_d = 4'b1101;
                2'd1: code_d = 4'b1110;
                2'd2: code_d = 4'b1111;
                2'd3: code_d = 4'b0000;
            endcase
        end else if (band_bin[0] == 2'd3) begin
            unique case (band_bin[1])
                2'd0:    code_d = 4'b1011;
                2'd1:    code_d = 4'b1010;
                default: code_d = 4'b1100;
            endcase
        end else begin
            code_d = 4'({2'b00, band_bin[0]} * 4'd3 + {2'b00, band_bin[1]} + 4'd1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            early_steer <= 1'b0;
            digit_code  <= 4'b0000;
        end else begin
            early_steer <= pair_ok;
            if (pair_ok) digit_code <= code_d;
        end
    end

endmodule

// File: rtl/dtmf_pair_decoder_chk.sv
module dtmf_pair_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       early_steer,
    input logic [3:0] digit_code,
    input logic [1:0] band_lock,
    input logic [1:0] band_edge
);
    AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        early_steer ##1 early_steer |-> $stable(digit_code)); // R10

    AST_STEER_NEEDS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(early_steer) |-> $past(&band_lock)); // R11

    AST_LOSS_DROPS_STEER: assert property (@(posedge clk) disable iff (!rst_n)
        !(&band_lock) |=> !early_steer); // R8

    AST_ROW_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(band_lock[0]) |-> $past(band_edge[0])); // R6

    AST_COL_LOCK_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(band_lock[1]) |-> $past(band_edge[1])); // R6

endmodule

bind dtmf_pair_decoder dtmf_pair_decoder_chk u_chk (
    .clk(clk),
    .rst_n(rst_n),
    .early_steer(early_steer),
    .digit_code(digit_code),
    .band_lock(band_lock),
    .band_edge(band_edge)
);

// File: tb/dtmf_pair_decoder_test.sv
module dtmf_pair_decoder_test;
    localparam longint REF_HZ = 200_000;
    localparam int     TOL    = 25;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tone_low = 1'b0, tone_high = 1'b0;
    logic       early_steer;
    logic [3:0] digit_code;

    always #10 clk = ~clk;

    dtmf_pair_decoder #(.CLK_HZ(REF_HZ), .TOL_PERMIL(TOL)) uut (
        .clk(clk), .rst_n(rst_n), .tone_low(tone_low), .tone_high(tone_high),
        .early_steer(early_steer), .digit_code(digit_code)
    );

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // tone generators: period in cycles, optional alternate period
    int          per [2] = '{0, 0};
    int          alt [2] = '{0, 0};
    int          ph  [2] = '{0, 0};
    int          cur [2] = '{0, 0};
    bit          flip[2] = '{0, 0};
    int          rises[2] = '{0, 0};
    int unsigned last_rise[2] = '{0, 0};

    initial begin
        bit tn [2];
        tn = '{0, 0};
        forever begin
            @(negedge clk);
            for (int b = 0; b < 2; b++) begin
                if (per[b] == 0) begin
                    tn[b] = 1'b0;
                    ph[b] = 0;
                end else begin
                    if (ph[b] == 0) begin
                        cur[b]  = (alt[b] != 0 && flip[b]) ? alt[b] : per[b];
                        flip[b] = ~flip[b];
                        rises[b]++;
                        last_rise[b] = cyc;
                    end
                    tn[b] = (ph[b] < cur[b] / 2);
                    ph[b]++;
                    if (ph[b] >= cur[b]) ph[b] = 0;
                end
            end
            tone_low  = tn[0];
            tone_high = tn[1];
        end
    end

    function automatic int ref_tone(int band, int idx);
        int rows [4] = '{697, 770, 852, 941};
        int cols [4] = '{1209, 1336, 1477, 1633};
        return band == 0 ? rows[idx] : cols[idx];
    endfunction

    function automatic int edge_of(int band, int idx, bit upper);
        longint num = REF_HZ * longint'(upper ? 1000 + TOL : 1000 - TOL);
        return int'(num / longint'(1000 * ref_tone(band, idx)));
    endfunction

    function automatic int classify(int band, int p);
        for (int k = 0; k < 4; k++)
            if (p >= edge_of(band, k, 0) && p <= edge_of(band, k, 1)) return k;
        return -1;
    endfunction

    function automatic int nominal(int band, int idx);
        int f = ref_tone(band, idx);
        return int'((REF_HZ + longint'(f / 2)) / longint'(f));
    endfunction

    function automatic int key_code(int r, int c);
        string pad = "123A456B789C*0#D";
        byte ch = pad[r * 4 + c];
        case (ch)
            "0": return 10;
            "*": return 11;
            "#": return 12;
            "A": return 13;
            "B": return 14;
            "C": return 15;
            "D": return 0;
            default: return int'(ch) - 48;
        endcase
    endfunction

    task automatic check(string req, int act, int exp, string what);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_cycles(int n);
        repeat (n) step();
    endtask

    task automatic trial(int pl, int phh, string req);
        int rl, rh, ev, first, bad;
        per[0] = pl; per[1] = phh; alt[0] = 0; alt[1] = 0;
        wait_cycles(1400);
        rl = classify(0, pl);
        rh = classify(1, phh);
        ev = (rl >= 0 && rh >= 0) ? 1 : 0;
        check(req, int'(early_steer), ev, $sformatf("steer p=%0d/%0d", pl, phh));
        if (ev == 1)
            check(req, int'(digit_code), key_code(rl, rh), $sformatf("code r%0d c%0d", rl, rh));
        first = int'(digit_code);
        bad = 0;
        repeat (600) begin
            step();
            if (int'(early_steer) != ev || (ev == 1 && int'(digit_code) != first)) bad++;
        end
        check("R10", bad, 0, "outputs held over window");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int base, c3, hits, lim;
        void'($urandom(32'd4711));
        wait_cycles(3);
        check("R1", int'(early_steer), 0, "steer in reset");
        rst_n = 1'b1;
        step();
        check("R1", int'(early_steer), 0, "steer after reset");

        // all sixteen keys at nominal period (R3 R4 R5 R11)
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                trial(nominal(0, r), nominal(1, c), (c == 3) ? "R5" : "R4");

        // bin bounds inclusive, one outside rejected (R2 R7)
        trial(edge_of(0, 0, 0), nominal(1, 1), "R2");
        trial(edge_of(0, 0, 1), nominal(1, 1), "R2");
        trial(edge_of(0, 0, 0) - 1, nominal(1, 1), "R7");
        trial(edge_of(1, 3, 1), nominal(0, 2), "R2");
        trial(nominal(0, 2), edge_of(1, 3, 1) + 1, "R7");
        // gap between 941 and 852 bins
        trial((edge_of(0, 3, 1) + edge_of(0, 2, 0)) / 2, nominal(1, 0), "R7");

        // alternating bins never lock (R6)
        per[0] = nominal(0, 0); alt[0] = nominal(0, 1); per[1] = nominal(1, 0);
        wait_cycles(600);
        hits = 0;
        repeat (3000) begin
            step();
            if (early_steer) hits++;
        end
        check("R6", hits, 0, "steer cycles with alternating row");
        alt[0] = 0;

        // rise latency (R9): row restarts from silence with column locked
        per[0] = 0; per[1] = nominal(1, 2);
        wait_cycles(1400);
        check("R8", int'(early_steer), 0, "silent row gives no steer");
        base = rises[0];
        per[0] = nominal(0, 1);
        while (rises[0] < base + 3) step();
        c3 = last_rise[0];
        while (cyc < c3 + 3) step();
        check("R9", int'(early_steer), 0, "steer on edge 3");
        step();
        check("R9", int'(early_steer), 1, "steer on edge 4");
        check("R4", int'(digit_code), key_code(1, 2), "code after lock");

        // fall latency (R8): stop row right after a rise
        wait_cycles(1000);
        base = rises[0];
        while (rises[0] == base) step();
        per[0] = 0;
        c3 = last_rise[0];
        lim = edge_of(0, 0, 1) + 1;
        while (cyc < c3 + lim + 3) step();
        check("R8", int'(early_steer), 1, "steer on edge LIMIT+3");
        step();
        check("R8", int'(early_steer), 0, "steer on edge LIMIT+4");

        // constrained random around chosen bins (R2 R7 R11)
        for (int t = 0; t < 20; t++) begin
            int r = int'($urandom % 4);
            int c = int'($urandom % 4);
            int lo0 = edge_of(0, r, 0) - 3, lo1 = edge_of(1, c, 0) - 3;
            int pl = lo0 + int'($urandom % (edge_of(0, r, 1) - lo0 + 4));
            int pc = lo1 + int'($urandom % (edge_of(1, c, 1) - lo1 + 4));
            trial(pl, pc, "R11");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule